// File: doc/BRIEF.md
# Page Write Load Controller

This block collects host writes into a page buffer of 128 byte slots and then launches one internal programming cycle for that page. The first write of a load fixes the page number, which is taken from the upper address bits. Every later write must address the same page. Each write stores its byte into the slot picked by the low address bits and marks that slot in a per-slot valid mask. The downstream programming logic then writes only the marked slots and leaves the rest of the page untouched.

The load window stays open while writes keep arriving within a gap limit, counted in clock cycles. When the gap limit expires, the block emits a one-cycle start pulse and holds a busy flag for a configurable number of cycles. It times the whole program phase by itself. While busy is high, the page number, the buffer and the mask are held steady for the array logic and all host writes are dropped. When busy falls, the mask is cleared.

The host side is a single-cycle write pulse with address and data. The front end that watches the chip-enable and write strobes produces this pulse. That front end takes the address at the later falling strobe edge and the data at the first rising edge, so the pulse carries both already resolved.

Top module: `page_load_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `prog_start`, `page_err` and every bit of `slot_valid` are 0.
- R2: A write pulse with the block idle opens a load window. It sets `page_num` to `wr_addr[16:7]`, stores `wr_data` in slot `wr_addr[6:0]` (bits `[8*s+7:8*s]` of `page_data`) and sets bit `wr_addr[6:0]` of `slot_valid`.
- R3: Within one window, slots may be written in any order, and a slot written more than once holds the data of its last write.
- R4: During a window, a write whose `wr_addr[16:7]` differs from `page_num` is dropped: buffer, mask and page stay unchanged. It sets `page_err`, which stays at 1 until reset, and it does not restart the gap count.
- R5: Suppose an accepted write occurs at clock edge k. A same-page write at edge k+j with 1 ≤ j ≤ LOAD_TIMEOUT joins the window. If no write is accepted at edges k+1 to k+LOAD_TIMEOUT, the window closes at edge k+LOAD_TIMEOUT.
- R6: `prog_start` is high for exactly one cycle, the first cycle in which `busy` is high.
- R7: `busy` stays high for exactly PROG_CYCLES cycles after the window closes, then falls with no host action.
- R8: Write pulses while `busy` is high are dropped: `page_num`, `page_data` and `slot_valid` do not change.
- R9: `slot_valid` is all zero in the cycle after `busy` falls.
- R10: `slot_valid` has exactly one bit set for each distinct slot accepted in the window, and no other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle host write pulse |
| wr_addr | input | 17 | Write address: page in [16:7], slot in [6:0] |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | High during the program phase |
| prog_start | output | 1 | One-cycle pulse when programming begins |
| page_num | output | 10 | Page latched by the first write of the window |
| page_data | output | 1024 | Flat page buffer, slot s in bits [8*s+7:8*s] |
| slot_valid | output | 128 | Per-slot loaded mask |
| page_err | output | 1 | Sticky flag for a write to a foreign page |

## Verification
On every cycle the assertions check the following:
- The start pulse lines up with the rising edge of busy.
- The page, the buffer and the mask stay frozen during busy.
- The mask only grows while loading, and it is empty once busy ends.
- The error flag stays set once it is set.
- The gap between writes never goes past the limit while the block is not busy.
- The length of the busy phase is exact.

Only the bench scenarios can show the rest:
- The data that ends up in each slot after out-of-order writes and overwrites.
- That a write at exactly the gap limit still joins the window, while one cycle later it is dropped.
- That a foreign-page write does not stretch the window.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_cycle_timer.sv
// Up-counter with synchronous clear and count enable; hit flags LIMIT-1.
module plc_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/plc_page_buf.sv
// Slot storage plus per-slot loaded mask.
module plc_page_buf #(
  parameter int SLOTS  = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       din,
  input  logic                    clr_mask,
  output logic [SLOTS*DATA_W-1:0] data_flat,
  output logic [SLOTS-1:0]        valid
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              hit_s;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic              vld_q, vld_d;

    assign hit_s = load && (idx == IDX_W'(s));

    always_comb begin
      byte_d = byte_q;
      vld_d  = vld_q;
      if (hit_s) begin
        byte_d = din;
        vld_d  = 1'b1;
      end else if (clr_mask) begin
        vld_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        byte_q <= byte_d;
        vld_q  <= vld_d;
      end
    end

    assign data_flat[s*DATA_W +: DATA_W] = byte_q;
    assign valid[s]                      = vld_q;
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int SLOTS        = 128,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 250000,
  localparam int SLOT_W      = $clog2(SLOTS),
  localparam int PAGE_W      = ADDR_W - SLOT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    busy,
  output logic                    prog_start,
  output logic [PAGE_W-1:0]       page_num,
  output logic [SLOTS*DATA_W-1:0] page_data,
  output logic [SLOTS-1:0]        slot_valid,
  output logic                    page_err
);
  plc_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              err_q, err_d;
  logic              start_q, start_d;

  logic [PAGE_W-1:0] wr_page;
  logic [SLOT_W-1:0] wr_slot;
  logic              same_page, accept, foreign, close_win, prog_done;
  logic              gap_hit, prog_hit;

  assign wr_page   = wr_addr[ADDR_W-1:SLOT_W];
  assign wr_slot   = wr_addr[SLOT_W-1:0];
  assign same_page = (wr_page == page_q);

  always_comb begin
    accept    = 1'b0;
    foreign   = 1'b0;
    close_win = 1'b0;
    prog_done = 1'b0;
    state_d   = state_q;
    page_d    = page_q;
    err_d     = err_q;
    case (state_q)
      ST_IDLE: begin
        if (wr_en) begin
          accept  = 1'b1;
          page_d  = wr_page;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (wr_en && same_page) begin
          accept = 1'b1;
        end else begin
          foreign = wr_en;
          if (gap_hit) begin
            close_win = 1'b1;
            state_d   = ST_PROG;
          end
        end
        if (foreign) err_d = 1'b1;
      end
      ST_PROG: begin
        if (prog_hit) begin
          prog_done = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    start_d = close_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      err_q   <= err_d;
      start_q <= start_d;
    end
  end

  plc_cycle_timer #(.LIMIT(LOAD_TIMEOUT)) u_gap_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (state_q == ST_LOAD),
    .hit   (gap_hit)
  );

  plc_cycle_timer #(.LIMIT(PROG_CYCLES)) u_prog_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (close_win),
    .en    (state_q == ST_PROG),
    .hit   (prog_hit)
  );

  plc_page_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_page_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .idx       (wr_slot),
    .din       (wr_data),
    .clr_mask  (prog_done),
    .data_flat (page_data),
    .valid     (slot_valid)
  );

  assign busy       = (state_q == ST_PROG);
  assign prog_start = start_q;
  assign page_num   = page_q;
  assign page_err   = err_q;
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int PAGE_W       = 10,
  parameter int SLOTS        = 128,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 16,
  parameter int PROG_CYCLES  = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    busy,
  input logic                    prog_start,
  input logic [PAGE_W-1:0]       page_num,
  input logic [SLOTS*DATA_W-1:0] page_data,
  input logic [SLOTS-1:0]        slot_valid,
  input logic                    page_err
);
  logic [31:0] gap_cnt, busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      busy_cnt <= '0;
    end else begin
      gap_cnt  <= (wr_en || busy || (slot_valid == '0)) ? 32'd0 : gap_cnt + 32'd1;
      busy_cnt <= busy ? busy_cnt + 32'd1 : 32'd0;
    end
  end

  AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);                                                   // R6
  AST_BUSY_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> prog_start);                                            // R6
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);                                            // R6
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(page_data) && $stable(slot_valid)
                               && $stable(page_num)));                      // R8
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (slot_valid == '0));                                    // R9
  AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((slot_valid & $past(slot_valid)) == $past(slot_valid)));     // R10
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid != '0) && ($past(slot_valid) != '0)) |-> $stable(page_num)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);                                                 // R4
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gap_cnt <= 32'(LOAD_TIMEOUT)));                              // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(PROG_CYCLES)));                        // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 32'(PROG_CYCLES)));                                // R7
endmodule

bind page_load_ctrl plc_checker #(
  .PAGE_W(PAGE_W), .SLOTS(SLOTS), .DATA_W(DATA_W),
  .LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)
) u_plc_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .prog_start(prog_start), .page_num(page_num), .page_data(page_data),
  .slot_valid(slot_valid), .page_err(page_err)
);

// File: tb/page_load_ctrl_bench.sv
module page_load_ctrl_bench;
  localparam int LOAD_T = 16;
  localparam int PROG_T = 20;
  localparam int NVEC   = 7;

  // vector: {idle cycles before write [7:0], slot [6:0], data [7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {8'd0,          7'h10, 8'hA5},
    {8'd1,          7'h03, 8'h3C},
    {8'd0,          7'h7F, 8'hFF},
    {8'd2,          7'h10, 8'h5A},
    {8'd0,          7'h00, 8'h01},
    {8'd3,          7'h40, 8'hC3},
    {8'(LOAD_T-1),  7'h22, 8'h77}
  };
  localparam logic [9:0] PAGE_A = 10'h155;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [16:0]   wr_addr;
  logic [7:0]    wr_data;
  logic          busy, prog_start, page_err;
  logic [9:0]    page_num;
  logic [1023:0] page_data;
  logic [127:0]  slot_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  page_load_ctrl #(.LOAD_TIMEOUT(LOAD_T), .PROG_CYCLES(PROG_T)) u_page_load_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_start(prog_start), .page_num(page_num),
    .page_data(page_data), .slot_valid(slot_valid), .page_err(page_err)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int nbusy;
    logic [127:0] exp_mask;
    logic         later;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    idle(3);
    chk("R1 busy in reset", busy, 0);
    chk("R1 mask in reset", slot_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 prog_start", prog_start, 0);
    chk("R1 err", page_err, 0);
    chk("R1 mask", slot_valid, 0);

    // table walk: one load window into PAGE_A
    exp_mask = '0;
    for (int i = 0; i < NVEC; i++) begin
      idle(int'(VEC[i][22:15]));
      do_write({PAGE_A, VEC[i][14:8]}, VEC[i][7:0]);
      exp_mask[VEC[i][14:8]] = 1'b1;
      if (i == 0) chk("R2 page latched", page_num, PAGE_A);
      chk("R5 window open", busy, 0);
    end
    chk("R5 write at gap limit joined", slot_valid[7'h22], 1);
    chk("R10 mask exact", slot_valid, exp_mask);
    chk("R10 mask count", $countones(slot_valid), 6);
    for (int i = 0; i < NVEC; i++) begin
      later = 1'b0;
      for (int j = i + 1; j < NVEC; j++)
        if (VEC[j][14:8] == VEC[i][14:8]) later = 1'b1;
      if (!later)
        chk("R3 slot data", page_data[8*VEC[i][14:8] +: 8], VEC[i][7:0]);
    end

    // foreign page write right after the last accepted one (edge k+1)
    do_write({10'h0AA, 7'h05}, 8'hEE);
    chk("R4 err set", page_err, 1);
    chk("R4 mask unchanged", slot_valid, exp_mask);
    chk("R4 page unchanged", page_num, PAGE_A);
    chk("R4 slot untouched", page_data[8*5 +: 8], 0);
    idle(LOAD_T - 2);
    chk("R4 gap not restarted, still loading", busy, 0);
    @(negedge clk);
    chk("R5 closed at limit", busy, 1);
    chk("R6 start pulse", prog_start, 1);
    nbusy = 1;

    // write during busy
    do_write({10'h0AA, 7'h09}, 8'h99);
    if (busy) nbusy++;
    chk("R6 start single", prog_start, 0);
    chk("R8 mask frozen", slot_valid, exp_mask);
    chk("R8 page frozen", page_num, PAGE_A);
    chk("R8 slot untouched", page_data[8*9 +: 8], 0);
    while (busy) begin
      @(negedge clk);
      if (busy) nbusy++;
    end
    chk("R7 busy length", nbusy, PROG_T);
    chk("R9 mask cleared", slot_valid, 0);
    chk("R4 err sticky", page_err, 1);

    // reset, then boundary slots and a write one cycle past the limit
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err cleared", page_err, 0);
    do_write({10'h003, 7'h00}, 8'h11);
    do_write({10'h003, 7'h7F}, 8'h22);
    chk("R2 page latched 2", page_num, 10'h003);
    chk("R10 edge slots", slot_valid, {1'b1, 126'b0, 1'b1});
    idle(LOAD_T);
    chk("R5 closed after gap", busy, 1);
    do_write({10'h003, 7'h01}, 8'h33);
    chk("R5 late write dropped", slot_valid, {1'b1, 126'b0, 1'b1});
    chk("R3 slot 127 data", page_data[8*127 +: 8], 8'h22);
    chk("R4 no err for dropped busy write", page_err, 0);
    while (busy) @(negedge clk);
    chk("R9 mask cleared 2", slot_valid, 0);
    finish_run();
  end
endmodule